// File: doc/BRIEF.md
# 40-bit Multiply-Accumulator with Accumulator Moves

This block keeps a single 40-bit signed accumulator and updates it from a stream of commands, at most one per clock. Three multiply-accumulate flavours are available. The first multiplies two full 32-bit signed words. The second multiplies packed halfword pairs and adds both products. The third multiplies one chosen halfword from each operand. Two move commands transfer a value into the accumulator from a pair of 32-bit words, or copy it out to a pair of 32-bit output words.

Each command carries an accumulator index. Only index zero addresses a real accumulator, and a command with any other index is discarded. The accumulator wraps modulo 2^40 and raises no flags. The two read words are registered: they are loaded only by a read command and hold their value until the next one.

Top module: `acc40_mac`

## Requirements
- R1: While reset is asserted, and after it is released, the accumulator and both read words are zero.
- R2: A valid opcode-0 command (full) adds the signed product of opA and opB, both taken as 32-bit two's complement, to the accumulator.
- R3: A valid opcode-1 command (dual) adds to the accumulator two signed 16x16 products, each sign-extended from 32 bits: opA[31:16]*opB[31:16] and opA[15:0]*opB[15:0].
- R4: A valid opcode-2 command (single) adds one signed 16x16 product. The A factor is opA[31:16] when selHiA is 1 and opA[15:0] when it is 0. The B factor is chosen from opB by selHiB in the same way.
- R5: A valid opcode-3 command (load) sets accumulator bits [31:0] to opA and bits [39:32] to opB[7:0].
- R6: A valid opcode-4 command (read) sets rdLo to accumulator bits [31:0] and rdHi to accumulator bits [39:32] sign-extended to 32 bits. Both are visible after the same clock edge.
- R7: Every accumulate result is truncated to 40 bits, so it wraps around with no saturation.
- R8: A command whose accIdx is not zero changes neither the accumulator nor the read words.
- R9: Opcodes 5, 6 and 7, and any cycle with cmdValid low, change neither the accumulator nor the read words.
- R10: A read captures the accumulator as it stood before its clock edge, and the read words keep that value through later updates until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Opcode: 0 full, 1 dual, 2 single, 3 load, 4 read |
| accIdx | input | 3 | Accumulator index; only 0 is valid |
| opA | input | 32 | First source word |
| opB | input | 32 | Second source word |
| selHiA | input | 1 | Single mode: take the upper half of opA |
| selHiB | input | 1 | Single mode: take the upper half of opB |
| rdLo | output | 32 | Read word, accumulator bits [31:0] |
| rdHi | output | 32 | Read word, accumulator bits [39:32] sign-extended |

## Verification
The bench targets three kinds of corner case. The first is the sign boundaries of the halfword products: -32768 times -32768 and mixed-sign pairs catch a design that extends from 16 bits instead of 32, or that swaps the half selects. The second is wraparound: loading 0x7F_FFFF_FFFF and adding one must flip the readout to a negative upper byte, while a design that saturates or keeps extra bits would show 0x7F or a wrong high word. The third is that commands with a non-zero index, reserved opcodes and idle cycles are issued between reads; a design that lets any of them through would show an altered accumulator at the next read.

// File: rtl/acc40_pkg.sv
package acc40_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_FULL = 3'd0,
    OP_DUAL = 3'd1,
    OP_HALF = 3'd2,
    OP_LOAD = 3'd3,
    OP_READ = 3'd4
  } accOp_e;

  typedef struct packed {
    logic doFull;
    logic doDual;
    logic doHalf;
    logic doLoad;
    logic doRead;
  } accStrobe_t;
endpackage

// File: rtl/acc40_ctrl.sv
module acc40_ctrl
  import acc40_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [OP_W-1:0]  cmdOp,
  input  logic [IDX_W-1:0] accIdx,
  output accStrobe_t       strb
);
  logic live;

  assign live = cmdValid && (accIdx == '0);

  always_comb begin
    strb = '0;
    if (live) begin
      unique case (cmdOp)
        OP_FULL: strb.doFull = 1'b1;
        OP_DUAL: strb.doDual = 1'b1;
        OP_HALF: strb.doHalf = 1'b1;
        OP_LOAD: strb.doLoad = 1'b1;
        OP_READ: strb.doRead = 1'b1;
        default: strb = '0;
      endcase
    end
  end

  // R8/R9: at most one action per cycle, and none for a foreign index
  a_r9_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
  a_r8_foreign_idx: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && accIdx != '0) |-> (strb == '0));
endmodule

// File: rtl/acc40_mul.sv
module acc40_mul #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ACC_W  = 40
) (
  input  logic              doFull,
  input  logic              doDual,
  input  logic              doHalf,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              selHiA,
  input  logic              selHiB,
  output logic [ACC_W-1:0]  addend
);
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned PROD_W = 2 * HALF_W;
  localparam int unsigned EXT_W  = ACC_W - PROD_W;
  localparam int unsigned WEXT_W = ACC_W - WORD_W;

  logic signed [ACC_W-1:0]  wideA, wideB, fullProd;
  logic signed [HALF_W-1:0] hiA, loA, hiB, loB, pickA, pickB;
  logic signed [PROD_W-1:0] hiProd, loProd, pickProd;
  logic [ACC_W-1:0]         hiExt, loExt, pickExt;

  assign wideA = {{WEXT_W{opA[WORD_W-1]}}, opA};
  assign wideB = {{WEXT_W{opB[WORD_W-1]}}, opB};
  // product modulo 2^ACC_W equals the low bits of the exact product
  assign fullProd = wideA * wideB;

  assign hiA = opA[WORD_W-1:HALF_W];
  assign loA = opA[HALF_W-1:0];
  assign hiB = opB[WORD_W-1:HALF_W];
  assign loB = opB[HALF_W-1:0];

  assign hiProd = hiA * hiB;
  assign loProd = loA * loB;

  assign pickA    = selHiA ? hiA : loA;
  assign pickB    = selHiB ? hiB : loB;
  assign pickProd = pickA * pickB;

  assign hiExt   = {{EXT_W{hiProd[PROD_W-1]}}, hiProd};
  assign loExt   = {{EXT_W{loProd[PROD_W-1]}}, loProd};
  assign pickExt = {{EXT_W{pickProd[PROD_W-1]}}, pickProd};

  always_comb begin
    addend = '0;
    if (doFull)      addend = fullProd;
    else if (doDual) addend = hiExt + loExt;
    else if (doHalf) addend = pickExt;
  end
endmodule

// File: rtl/acc40_dp.sv
module acc40_dp
  import acc40_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrobe_t        strb,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              selHiA,
  input  logic              selHiB,
  output logic [WORD_W-1:0] rdLo,
  output logic [WORD_W-1:0] rdHi
);
  localparam int unsigned TOP_W = ACC_W - WORD_W;
  localparam int unsigned PAD_W = WORD_W - TOP_W;

  logic [ACC_W-1:0] accReg, addend;
  logic             doMac;

  acc40_mul #(.WORD_W(WORD_W), .ACC_W(ACC_W)) uMul (
    .doFull (strb.doFull),
    .doDual (strb.doDual),
    .doHalf (strb.doHalf),
    .opA    (opA),
    .opB    (opB),
    .selHiA (selHiA),
    .selHiB (selHiB),
    .addend (addend)
  );

  assign doMac = strb.doFull | strb.doDual | strb.doHalf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg <= '0;
    end else if (strb.doLoad) begin
      accReg <= {opB[TOP_W-1:0], opA};
    end else if (doMac) begin
      accReg <= accReg + addend;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdLo <= '0;
      rdHi <= '0;
    end else if (strb.doRead) begin
      rdLo <= accReg[WORD_W-1:0];
      rdHi <= {{PAD_W{accReg[ACC_W-1]}}, accReg[ACC_W-1:WORD_W]};
    end
  end

  a_r5_load_place: assert property (@(posedge clk) disable iff (!rstN)
    strb.doLoad |=> (accReg == {$past(opB[TOP_W-1:0]), $past(opA)}));
  a_r9_acc_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !(doMac || strb.doLoad) |=> $stable(accReg));
  a_r10_read_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doRead |=> ($stable(rdLo) && $stable(rdHi)));
  a_r6_hi_sext: assert property (@(posedge clk) disable iff (!rstN)
    (rdHi[WORD_W-1:TOP_W] == {PAD_W{rdHi[TOP_W-1]}}));
  a_r10_read_old: assert property (@(posedge clk) disable iff (!rstN)
    strb.doRead |=> (rdLo == $past(accReg[WORD_W-1:0])));
endmodule

// File: rtl/acc40_mac.sv
module acc40_mac
  import acc40_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [OP_W-1:0]   cmdOp,
  input  logic [IDX_W-1:0]  accIdx,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              selHiA,
  input  logic              selHiB,
  output logic [WORD_W-1:0] rdLo,
  output logic [WORD_W-1:0] rdHi
);
  accStrobe_t strb;

  acc40_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .accIdx   (accIdx),
    .strb     (strb)
  );

  acc40_dp #(.WORD_W(WORD_W), .ACC_W(ACC_W)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .opA    (opA),
    .opB    (opB),
    .selHiA (selHiA),
    .selHiB (selHiB),
    .rdLo   (rdLo),
    .rdHi   (rdHi)
  );
endmodule

// File: tb/tb_acc40_mac.sv
`timescale 1ns/1ps
module tb_acc40_mac;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [2:0]  accIdx = '0;
  logic [31:0] opA = '0, opB = '0;
  logic        selHiA = 1'b0, selHiB = 1'b0;
  logic [31:0] rdLo, rdHi;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [39:0] mAcc;
  logic [31:0] mLo, mHi;

  always #2.5 clk = ~clk;

  acc40_mac dut (.clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .accIdx(accIdx), .opA(opA), .opB(opB), .selHiA(selHiA), .selHiB(selHiB),
    .rdLo(rdLo), .rdHi(rdHi));

  function automatic logic [39:0] sx16(input logic [15:0] h1, input logic [15:0] h2);
    logic signed [31:0] p;
    p = $signed(h1) * $signed(h2);
    return {{8{p[31]}}, p};
  endfunction

  function automatic logic [39:0] fullMul(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] p;
    p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    return p[39:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one command; model updated after the edge, outputs compared 1 ns later
  task automatic cmd(input bit v, input logic [2:0] op, input logic [2:0] idx,
                     input logic [31:0] a, input logic [31:0] b,
                     input bit sa, input bit sb, input string tag);
    cmdValid = v; cmdOp = op; accIdx = idx; opA = a; opB = b;
    selHiA = sa; selHiB = sb;
    @(posedge clk);
    #1;
    if (v && idx == 0) begin
      case (op)
        3'd0: mAcc = mAcc + fullMul(a, b);
        3'd1: mAcc = mAcc + sx16(a[31:16], b[31:16]) + sx16(a[15:0], b[15:0]);
        3'd2: mAcc = mAcc + sx16(sa ? a[31:16] : a[15:0], sb ? b[31:16] : b[15:0]);
        3'd3: mAcc = {b[7:0], a};
        3'd4: begin mLo = mAcc[31:0]; mHi = {{24{mAcc[39]}}, mAcc[39:32]}; end
        default: ;
      endcase
    end
    cmdValid = 1'b0;
    chk({tag, " lo"}, rdLo, mLo);
    chk({tag, " hi"}, rdHi, mHi);
  endtask

  task automatic rd(input string tag);
    cmd(1, 3'd4, 0, '0, '0, 0, 0, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    mAcc = '0; mLo = '0; mHi = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset lo", rdLo, 32'h0);
    chk("R1 reset hi", rdHi, 32'h0);
    rstN = 1'b1;
    rd("R1 read after reset");

    // R5/R6: load then read, negative top byte
    cmd(1, 3'd3, 0, 32'h1234_5678, 32'hFFFF_FF9A, 0, 0, "R5 load");
    rd("R6 read sign-extended");
    // R7: wrap from largest positive to most negative
    cmd(1, 3'd3, 0, 32'hFFFF_FFFF, 32'h0000_007F, 0, 0, "R5 load max");
    cmd(1, 3'd0, 0, 32'h1, 32'h1, 0, 0, "R2 full +1");
    rd("R7 wrap to negative");
    cmd(1, 3'd3, 0, 32'hFFFF_FFFF, 32'h0000_00FF, 0, 0, "R5 load -1");
    cmd(1, 3'd0, 0, 32'h1, 32'h1, 0, 0, "R2 full");
    rd("R7 wrap to zero");
    // R2: negative operands
    cmd(1, 3'd0, 0, 32'h8000_0000, 32'h8000_0000, 0, 0, "R2 min*min");
    rd("R2 min*min");
    // R3: extreme halves
    cmd(1, 3'd3, 0, 32'h0, 32'h0, 0, 0, "R5 clear");
    cmd(1, 3'd1, 0, 32'h8000_FFFF, 32'h8000_0002, 0, 0, "R3 dual");
    rd("R3 dual");
    // R4: every select combination
    for (int s = 0; s < 4; s++) begin
      cmd(1, 3'd2, 0, 32'h8000_7FFF, 32'hFFFE_0003, s[1], s[0], "R4 single");
      rd("R4 single");
    end
    // R8/R9: ignored commands between reads
    cmd(1, 3'd3, 0, 32'hCAFE_0001, 32'h0000_0011, 0, 0, "R5 load");
    cmd(1, 3'd3, 3'd1, 32'h0, 32'h0, 0, 0, "R8 load foreign");
    cmd(1, 3'd0, 3'd7, 32'h5, 32'h5, 0, 0, "R8 full foreign");
    cmd(1, 3'd4, 3'd2, 32'h0, 32'h0, 0, 0, "R8 read foreign");
    for (int o = 5; o < 8; o++) cmd(1, o[2:0], 0, 32'h7, 32'h7, 0, 0, "R9 reserved op");
    cmd(0, 3'd0, 0, 32'h9, 32'h9, 0, 0, "R9 not valid");
    rd("R8 R9 acc intact");
    // R10: read then update, readout holds old value
    cmd(1, 3'd0, 0, 32'h100, 32'h100, 0, 0, "R10 update after read");
    cmd(1, 3'd1, 0, 32'h0101_0101, 32'h0202_0202, 0, 0, "R10 update after read");
    rd("R10 new read");

    for (int i = 0; i < 3000; i++) begin
      logic [2:0] op, idx;
      op  = 3'($urandom % 8);
      idx = ($urandom % 8 == 0) ? 3'($urandom) : 3'd0;
      cmd(($urandom % 10) != 0, op, idx, $urandom, $urandom, 1'($urandom), 1'($urandom),
          "R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end
    rd("R6 final read");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule